// File: doc/BRIEF.md
# Bus-Programmed Watchdog Timer

This block is a watchdog peripheral on an APB slave port. Software writes a 32-bit start value, and a 32-bit counter then steps down by one on each cycle where the `tick_en` strobe is high. The strobe comes from a slow time base that is separate from the bus clock. When the counter steps from one to zero, the block latches a raw interrupt flag. The counter stays at zero until the next tick and reloads from the start value on that tick.

Software services the watchdog by writing any value to a clear register. That write drops the flag and restarts the count from the start value in the same cycle. If the counter reaches zero again while the flag is still set and the reset enable is on, the block raises a sticky reset request. A key register protects every other register against stray writes.

Top module: `apb_wdog_timer`

## Requirements
- R1: After reset, the start-value register (offset 0x00) and the counter (offset 0x04) both read 0xFFFFFFFF. The raw flag (offset 0x10, bit 0) reads 0, `irq` and `rst_req` are 0, and the block is unlocked.
- R2: A write to offset 0x00 stores the start value and loads the counter with the same value on that clock.
- R3: With control bit 0 (offset 0x08) set, each cycle with `tick_en` high lowers the counter by one. Cycles without `tick_en` leave the counter unchanged. With control bit 0 clear, the counter holds its value.
- R4: A tick that takes the counter from 1 to 0 sets the raw flag. The counter then reads 0 until the next tick.
- R5: A tick taken while the counter is 0 reloads the counter from the start value.
- R6: A write of any data to offset 0x0C clears the raw flag and reloads the counter from the start value on that clock.
- R7: `irq` and the masked status (offset 0x14, bit 0) equal the raw flag ANDed with control bit 0.
- R8: With control bit 1 set, a step from 1 to 0 that happens while the raw flag is already set raises `rst_req`. `rst_req` then stays high until `rst_n` is asserted, and clearing the flag does not drop it.
- R9: Writing 0x1ACCE551 to offset 0xC00 unlocks the block, and writing any other value locks it. Reading 0xC00 returns bit 0 = 1 while locked. While locked, writes to all other offsets have no effect.
- R10: Every access completes with `pready` = 1 and `pslverr` = 0. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| tick_en | input | 1 | Count strobe from the slow time base |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write |
| paddr | input | 12 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, always high |
| pslverr | output | 1 | APB error, always low |
| irq | output | 1 | Masked interrupt |
| rst_req | output | 1 | Sticky reset request |

## Verification
A long directed run uses a start value of 1000 and a midpoint service. It separates the step to zero, the one-tick hold at zero and the reload. It also shows that a service write restarts the count immediately rather than on a tick.

Random sequences mix small start values (zero included), bursts of ticks, service writes and enable toggles. These sequences expose off-by-one errors around zero and reload, and they confirm that the counter holds when disabled. Directed cases for the key register and the second timeout show that locked writes are dropped and that the reset request survives a service write.

// File: rtl/apb_wdog_timer.sv
module apb_wdog_timer #(
  parameter int          AW  = 12,
  parameter logic [31:0] KEY = 32'h1ACCE551
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  input  logic [31:0]   pwdata,
  output logic [31:0]   prdata,
  output logic          pready,
  output logic          pslverr,
  output logic          irq,
  output logic          rst_req
);
  localparam logic [AW-1:0] OFS_LOAD = AW'('h000);
  localparam logic [AW-1:0] OFS_CNT  = AW'('h004);
  localparam logic [AW-1:0] OFS_CTRL = AW'('h008);
  localparam logic [AW-1:0] OFS_CLR  = AW'('h00C);
  localparam logic [AW-1:0] OFS_RAW  = AW'('h010);
  localparam logic [AW-1:0] OFS_MSK  = AW'('h014);
  localparam logic [AW-1:0] OFS_LOCK = AW'('hC00);

  logic [31:0] load, count;
  logic [1:0]  ctrl;
  logic        raw, locked;

  wire wr      = psel & penable & pwrite;
  wire wr_ok   = wr & ~locked;
  wire tick_on = tick_en & ctrl[0];

  assign pready  = 1'b1;
  assign pslverr = 1'b0;
  assign irq     = raw & ctrl[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load    <= '1;
      count   <= '1;
      ctrl    <= '0;
      raw     <= 1'b0;
      locked  <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      if (wr && paddr == OFS_LOCK) locked <= (pwdata != KEY);
      if (wr_ok && paddr == OFS_CTRL) ctrl <= pwdata[1:0];
      if (wr_ok && paddr == OFS_LOAD) begin
        load  <= pwdata;
        count <= pwdata;
      end else if (wr_ok && paddr == OFS_CLR) begin
        raw   <= 1'b0;
        count <= load;
      end else if (tick_on) begin
        if (count == '0) begin
          count <= load;
        end else begin
          count <= count - 32'd1;
          if (count == 32'd1) begin
            raw <= 1'b1;
            if (raw && ctrl[1]) rst_req <= 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    prdata = '0;
    if (psel && !pwrite) begin
      case (paddr)
        OFS_LOAD: prdata = load;
        OFS_CNT:  prdata = count;
        OFS_CTRL: prdata = {30'd0, ctrl};
        OFS_RAW:  prdata = {31'd0, raw};
        OFS_MSK:  prdata = {31'd0, irq};
        OFS_LOCK: prdata = {31'd0, locked};
        default:  prdata = '0;
      endcase
    end
  end

  a_r3_hold_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!ctrl[0] && !wr) |-> count == $past(count));

  a_r4_flag_from_one: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw) |-> $past(count) == 32'd1 && count == '0);

  a_r5_reload_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tick_on && count == '0 && !wr) |-> count == $past(load));

  a_r6_clear_reloads: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_ok && paddr == OFS_CLR) |-> !raw && count == $past(load));

  a_r8_reset_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_req) |-> rst_req);

  a_r9_locked_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    $past(locked && wr && paddr != OFS_LOCK) |-> load == $past(load) && ctrl == $past(ctrl));
endmodule

// File: tb/sim_apb_wdog_timer.sv
module sim_apb_wdog_timer;
  localparam int PER = 10;
  localparam logic [31:0] KEY = 32'h1ACCE551;

  logic clk = 0, rst_n = 0, tick_en = 0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic pready, pslverr, irq, rst_req;

  int checks = 0, errors = 0;

  logic [31:0] m_load, m_count;
  logic [1:0]  m_ctrl;
  logic        m_raw, m_lock, m_rst;

  apb_wdog_timer u0 (.clk(clk), .rst_n(rst_n), .tick_en(tick_en), .psel(psel),
    .penable(penable), .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
    .prdata(prdata), .pready(pready), .pslverr(pslverr), .irq(irq), .rst_req(rst_req));

  always #(PER/2) clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic void model_reset();
    m_load = '1; m_count = '1; m_ctrl = 0; m_raw = 0; m_lock = 0; m_rst = 0;
  endfunction

  function automatic void model_tick();
    if (!m_ctrl[0]) return;
    if (m_count == 0) m_count = m_load;
    else begin
      if (m_count == 1) begin
        if (m_raw && m_ctrl[1]) m_rst = 1;
        m_raw = 1;
      end
      m_count--;
    end
  endfunction

  function automatic void model_write(logic [11:0] a, logic [31:0] d);
    if (a == 12'hC00) begin m_lock = (d != KEY); return; end
    if (m_lock) return;
    case (a)
      12'h000: begin m_load = d; m_count = d; end
      12'h008: m_ctrl = d[1:0];
      12'h00C: begin m_raw = 0; m_count = m_load; end
      default: ;
    endcase
  endfunction

  task automatic apb_write(logic [11:0] a, logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    model_write(a, d);
  endtask

  task automatic apb_read(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk); penable = 1;
    #1 d = prdata;
    chk("R10 pready", {31'd0, pready}, 1);
    chk("R10 pslverr", {31'd0, pslverr}, 0);
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic ticks(int n);
    @(negedge clk); tick_en = 1;
    repeat (n) @(negedge clk);
    tick_en = 0;
    repeat (n) model_tick();
  endtask

  task automatic rd_chk(string req, logic [11:0] a, logic [31:0] exp);
    logic [31:0] d;
    apb_read(a, d);
    chk(req, d, exp);
  endtask

  task automatic do_reset();
    rst_n = 0; repeat (2) @(negedge clk); rst_n = 1;
    model_reset();
  endtask

  initial begin
    #(PER * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int op;
    model_reset();
    do_reset();
    // R1
    rd_chk("R1 load", 12'h000, 32'hFFFFFFFF);
    rd_chk("R1 count", 12'h004, 32'hFFFFFFFF);
    rd_chk("R1 raw", 12'h010, 0);
    rd_chk("R1 lock", 12'hC00, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 rst_req", {31'd0, rst_req}, 0);

    // R2 R3 R4 R5 R6 long directed run
    apb_write(12'h008, 1);
    apb_write(12'h000, 1000);
    rd_chk("R2 count loaded", 12'h004, 1000);
    ticks(500);
    rd_chk("R3 count 500", 12'h004, 500);
    rd_chk("R3 raw 0", 12'h010, 0);
    ticks(500);
    rd_chk("R4 count 0", 12'h004, 0);
    rd_chk("R4 raw 1", 12'h010, 1);
    chk("R7 irq", {31'd0, irq}, 1);
    repeat (5) @(negedge clk);
    rd_chk("R4 holds 0 without tick", 12'h004, 0);
    ticks(1);
    rd_chk("R5 reload", 12'h004, 1000);
    ticks(500);
    rd_chk("R6 pre", 12'h004, 500);
    apb_write(12'h00C, 32'hDEAD0000);
    rd_chk("R6 count", 12'h004, 1000);
    rd_chk("R6 raw", 12'h010, 0);

    // R3 disabled hold, R7 masking
    apb_write(12'h000, 2);
    ticks(2);
    apb_write(12'h008, 0);
    ticks(7);
    rd_chk("R3 disabled hold", 12'h004, 0);
    rd_chk("R7 raw kept", 12'h010, 1);
    rd_chk("R7 masked reg", 12'h014, 0);
    chk("R7 irq masked", {31'd0, irq}, 0);

    // R10 unmapped
    rd_chk("R10 unmapped", 12'h020, 0);
    rd_chk("R10 unmapped 2", 12'h800, 0);

    // R9 lock
    apb_write(12'hC00, 0);
    rd_chk("R9 locked", 12'hC00, 1);
    apb_write(12'h000, 77);
    apb_write(12'h008, 1);
    rd_chk("R9 load ignored", 12'h000, 2);
    rd_chk("R9 ctrl ignored", 12'h008, 0);
    apb_write(12'h00C, 0);
    rd_chk("R9 clear ignored", 12'h010, 1);
    apb_write(12'hC00, KEY);
    rd_chk("R9 unlocked", 12'hC00, 0);
    apb_write(12'h000, 77);
    rd_chk("R9 load after unlock", 12'h000, 77);

    // R8 second timeout
    apb_write(12'h00C, 0);
    apb_write(12'h008, 3);
    apb_write(12'h000, 3);
    ticks(3);
    chk("R8 first timeout no reset", {31'd0, rst_req}, 0);
    ticks(3);
    chk("R8 before second", {31'd0, rst_req}, 0);
    ticks(1);
    chk("R8 second timeout", {31'd0, rst_req}, 1);
    apb_write(12'h00C, 0);
    chk("R8 sticky after clear", {31'd0, rst_req}, 1);
    do_reset();
    chk("R8 cleared by reset", {31'd0, rst_req}, 0);

    // random mix
    op = $urandom(32'd2024);
    for (int i = 0; i < 400; i++) begin
      op = $urandom_range(0, 9);
      case (op)
        0, 1: apb_write(12'h000, $urandom_range(0, 12));
        2: apb_write(12'h00C, $urandom());
        3: apb_write(12'h008, $urandom_range(0, 3));
        4, 5, 6: ticks($urandom_range(1, 15));
        7: rd_chk("R3 rand count", 12'h004, m_count);
        8: rd_chk("R4 rand raw", 12'h010, {31'd0, m_raw});
        default: begin
          rd_chk("R7 rand masked", 12'h014, {31'd0, m_raw & m_ctrl[0]});
          chk("R8 rand rst_req", {31'd0, rst_req}, {31'd0, m_rst});
        end
      endcase
    end
    rd_chk("R5 final count", 12'h004, m_count);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule